// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves a translation after a TLB miss by searching a hashed page table held in memory. A request carries a virtual page number, a process identifier and the untranslated page offset. The walker folds the identifier and page number into a slot index and adds that slot to a table base address that is captured with the request. It then fetches the slot's entries one by one through a single-outstanding memory read port. Each fetched entry is compared against the request tag before the next read is issued.

When the primary slot yields no valid matching entry, the walker complements the primary index and searches that second slot in the same way. No software takes part in this. A hit returns the physical page number, the full physical address, the entry position and which slot supplied it. If both slots come up empty, a miss response tells software to fall back to its complete translation structure. Only one walk runs at a time, and acceptance follows a ready/valid handshake.

Top module: `hpt_walker`

## Requirements
- R1: The primary slot index is the XOR of consecutive 6-bit chunks of the 28-bit key {pid, vpn}, zero-padded at the top to 30 bits. An entry lives at byte address base + index*64 + position*8, where base is sampled when the request is accepted.
- R2: Entries of a slot are read in ascending position order 0 to 7. `mem_req` is high for exactly one cycle per read, and the next read is issued only after `mem_rsp_valid` returns the previous entry.
- R3: An entry word is {valid[44], pid[43:36], vpn[35:16], ppn[15:0]}. It matches only when valid is 1 and both its pid and vpn equal the request's. Invalid entries and entries with a different pid never match.
- R4: The search stops at the first matching entry, so a later duplicate match is never read. The response reports that entry's position in `rsp_way`.
- R5: If all 8 primary entries miss, the slot whose index is the bitwise complement of the primary index (6 bits) is searched in the same order. `rsp_secondary` is 1 for a result found there and 0 for a primary result.
- R6: When both slots miss, exactly 16 reads occur. The response then has `rsp_hit`=0, `rsp_ppn`=0, `rsp_secondary`=1 and `rsp_way`=7.
- R7: On a hit, `rsp_paddr` equals {ppn, offset}, with the offset taken unchanged from the request.
- R8: `req_ready` is low from the cycle after acceptance until the walk's response has been given. A request presented while busy is ignored and starts no memory read.
- R9: The memory response latency may be any number of cycles, and the result does not depend on it.
- R10: After reset, `req_ready`=1, `mem_req`=0 and `rsp_valid`=0.
- R11: `rsp_valid` is a single-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | Byte base address of the hashed table, sampled on accept |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | 20 | Virtual page number |
| req_pid | input | 8 | Process identifier |
| req_off | input | 12 | Page offset, passed through |
| mem_req | output | 1 | Read request, one cycle per entry |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 45 | Entry word read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_hit | output | 1 | 1 when a translation was found |
| rsp_ppn | output | 16 | Physical page number (0 on miss) |
| rsp_paddr | output | 28 | Physical address {ppn, offset} |
| rsp_way | output | 3 | Position of the matching entry, or 7 on miss |
| rsp_secondary | output | 1 | Result came from the complement slot |

## Verification
On every cycle, the assertions check the handshake rules: one read outstanding, no read while idle, the walker busy after acceptance, and a response that lasts a single cycle. They also check that a miss is reported only after the secondary slot has been searched. Only the bench's scenarios can show which entry wins and where it sits. They plant matches, invalid or foreign-pid decoys and duplicates at chosen positions in either slot. The bench then compares the walk's exact read-address sequence, read count and result fields with values computed from the hash definition, and it does this under varied and long memory latencies and with requests presented while busy.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
    parameter int VPN_W       = 20;
    parameter int PID_W       = 8;
    parameter int PPN_W       = 16;
    parameter int OFF_W       = 12;
    parameter int IDX_W       = 6;
    parameter int WAYS        = 8;
    parameter int ADDR_W      = 32;
    parameter int ENTRY_BYTES = 8;

    localparam int WAY_W     = $clog2(WAYS);
    localparam int ENTRY_SH  = $clog2(ENTRY_BYTES);
    localparam int SLOT_SH   = ENTRY_SH + WAY_W;
    localparam int KEY_W     = PID_W + VPN_W;
    localparam int FOLD_N    = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int KEY_PAD_W = FOLD_N * IDX_W;
    localparam int PA_W      = PPN_W + OFF_W;

    // Entry word as stored in memory, valid bit on top.
    typedef struct packed {
        logic             valid;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    // Request captured for the duration of a walk.
    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } xlat_req_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT,
        W_DONE
    } walk_state_e;

    // Primary index: XOR fold of the zero-padded key in IDX_W chunks.
    function automatic logic [IDX_W-1:0] fold_hash(
        input logic [PID_W-1:0] pid,
        input logic [VPN_W-1:0] vpn
    );
        logic [KEY_PAD_W-1:0] key;
        logic [IDX_W-1:0]     acc;
        key = KEY_PAD_W'({pid, vpn});
        acc = '0;
        for (int i = 0; i < FOLD_N; i++) begin
            acc = acc ^ key[i*IDX_W +: IDX_W];
        end
        return acc;
    endfunction

    // Secondary index: complement of the primary within the index width.
    function automatic logic [IDX_W-1:0] alt_hash(input logic [IDX_W-1:0] prim);
        return ~prim;
    endfunction
endpackage

// File: rtl/hptw_addr_gen.sv
module hptw_addr_gen
    import hptw_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [PID_W-1:0]  pid,
    input  logic [VPN_W-1:0]  vpn,
    input  logic              use_alt,
    input  logic [WAY_W-1:0]  way,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [IDX_W-1:0] prim_idx;
    logic [IDX_W-1:0] slot_idx;

    always_comb begin
        prim_idx   = fold_hash(pid, vpn);
        slot_idx   = use_alt ? alt_hash(prim_idx) : prim_idx;
        entry_addr = base
                   + (ADDR_W'(slot_idx) << SLOT_SH)
                   + (ADDR_W'(way) << ENTRY_SH);
    end
endmodule

// File: rtl/hptw_tag_cmp.sv
module hptw_tag_cmp
    import hptw_pkg::*;
(
    input  logic [PTE_W-1:0] entry_word,
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    output logic             match,
    output logic [PPN_W-1:0] ppn
);
    pte_t entry;

    always_comb begin
        entry = pte_t'(entry_word);
        match = entry.valid && (entry.pid == pid) && (entry.vpn == vpn);
        ppn   = entry.ppn;
    end
endmodule

// File: rtl/hptw_ctrl.sv
module hptw_ctrl
    import hptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  xlat_req_t         req_in,
    output logic              mem_req,
    input  logic              mem_rsp_valid,
    input  logic              entry_match,
    input  logic [PPN_W-1:0]  entry_ppn,
    output xlat_req_t         cur_req,
    output logic [ADDR_W-1:0] cur_base,
    output logic [WAY_W-1:0]  cur_way,
    output logic              cur_alt,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PA_W-1:0]   rsp_paddr
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    walk_state_e      st_q;
    logic             hit_q;
    logic [PPN_W-1:0] ppn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= W_IDLE;
            cur_req  <= '0;
            cur_base <= '0;
            cur_way  <= '0;
            cur_alt  <= 1'b0;
            hit_q    <= 1'b0;
            ppn_q    <= '0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (req_valid) begin
                        cur_req  <= req_in;
                        cur_base <= tbl_base;
                        cur_way  <= '0;
                        cur_alt  <= 1'b0;
                        hit_q    <= 1'b0;
                        ppn_q    <= '0;
                        st_q     <= W_ISSUE;
                    end
                end
                W_ISSUE: st_q <= W_WAIT;
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (entry_match) begin
                            hit_q <= 1'b1;
                            ppn_q <= entry_ppn;
                            st_q  <= W_DONE;
                        end else if (cur_way != LAST_WAY) begin
                            cur_way <= cur_way + 1'b1;
                            st_q    <= W_ISSUE;
                        end else if (!cur_alt) begin
                            cur_alt <= 1'b1;
                            cur_way <= '0;
                            st_q    <= W_ISSUE;
                        end else begin
                            st_q <= W_DONE;
                        end
                    end
                end
                W_DONE: st_q <= W_IDLE;
                default: st_q <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (st_q == W_IDLE);
        mem_req   = (st_q == W_ISSUE);
        rsp_valid = (st_q == W_DONE);
        rsp_hit   = hit_q;
        rsp_ppn   = hit_q ? ppn_q : '0;
        rsp_paddr = {rsp_ppn, cur_req.off};
    end

    AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R2
    AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R11
    AST_MISS_AFTER_BOTH_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (cur_alt && cur_way == LAST_WAY)); // R6
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [OFF_W-1:0]  req_off,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_secondary
);
    xlat_req_t         req_in;
    xlat_req_t         cur_req;
    logic [ADDR_W-1:0] cur_base;
    logic [WAY_W-1:0]  cur_way;
    logic              cur_alt;
    logic              entry_match;
    logic [PPN_W-1:0]  entry_ppn;

    assign req_in = '{pid: req_pid, vpn: req_vpn, off: req_off};

    hptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tbl_base      (tbl_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_in        (req_in),
        .mem_req       (mem_req),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_match   (entry_match),
        .entry_ppn     (entry_ppn),
        .cur_req       (cur_req),
        .cur_base      (cur_base),
        .cur_way       (cur_way),
        .cur_alt       (cur_alt),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_ppn       (rsp_ppn),
        .rsp_paddr     (rsp_paddr)
    );

    hptw_addr_gen u_addr (
        .base       (cur_base),
        .pid        (cur_req.pid),
        .vpn        (cur_req.vpn),
        .use_alt    (cur_alt),
        .way        (cur_way),
        .entry_addr (mem_addr)
    );

    hptw_tag_cmp u_cmp (
        .entry_word (mem_rsp_data),
        .pid        (cur_req.pid),
        .vpn        (cur_req.vpn),
        .match      (entry_match),
        .ppn        (entry_ppn)
    );

    assign rsp_way       = cur_way;
    assign rsp_secondary = cur_alt;
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
    // where: 0 = primary slot, 1 = secondary slot, 2 = absent
    typedef struct packed {
        logic [19:0] vpn;
        logic [7:0]  pid;
        logic [11:0] off;
        logic [1:0]  where;
        logic [2:0]  way;
        logic        decoy;
        logic        dup;
        logic [15:0] ppn;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{20'h12345, 8'h01, 12'habc, 2'd0, 3'd0, 1'b0, 1'b0, 16'h1111},
        '{20'h0beef, 8'h22, 12'h001, 2'd0, 3'd7, 1'b1, 1'b0, 16'h2222},
        '{20'h55aa5, 8'h3c, 12'hfff, 2'd0, 3'd3, 1'b0, 1'b1, 16'h3333},
        '{20'h00000, 8'h00, 12'h123, 2'd1, 3'd0, 1'b0, 1'b0, 16'h4444},
        '{20'h9f0e1, 8'h7e, 12'h456, 2'd1, 3'd6, 1'b1, 1'b1, 16'h5555},
        '{20'h31415, 8'h92, 12'h789, 2'd2, 3'd0, 1'b0, 1'b0, 16'h0000},
        '{20'h27182, 8'h18, 12'h321, 2'd2, 3'd0, 1'b1, 1'b0, 16'h0000},
        '{20'hfffff, 8'hff, 12'h800, 2'd0, 3'd4, 1'b1, 1'b0, 16'hbeef}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] tbl_base;
    logic        req_valid;
    logic        req_ready;
    logic [19:0] req_vpn;
    logic [7:0]  req_pid;
    logic [11:0] req_off;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid;
    logic [44:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [15:0] rsp_ppn;
    logic [27:0] rsp_paddr;
    logic [2:0]  rsp_way;
    logic        rsp_secondary;

    always #5 clk = ~clk;

    hpt_walker u_dut (
        .clk           (clk),
        .rst           (rst),
        .tbl_base      (tbl_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vpn       (req_vpn),
        .req_pid       (req_pid),
        .req_off       (req_off),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_ppn       (rsp_ppn),
        .rsp_paddr     (rsp_paddr),
        .rsp_way       (rsp_way),
        .rsp_secondary (rsp_secondary)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [44:0] mem [512];
    logic [31:0] addr_log [32];
    int          n_reads  = 0;
    int          rsp_seen = 0;
    int          fixed_lat = -1;
    int          lat_seed  = 0;
    int          pending   = 0;
    int          lat_cnt   = 0;
    logic [31:0] pend_addr;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [7:0] pid, input logic [19:0] vpn);
        logic [27:0] key;
        logic [5:0]  h;
        key = {pid, vpn};
        h = '0;
        for (int b = 0; b < 28; b++) h[b % 6] = h[b % 6] ^ key[b];
        return h;
    endfunction

    function automatic logic [44:0] mk(input logic v, input logic [7:0] p, input logic [19:0] vp, input logic [15:0] pp);
        return {v, p, vp, pp};
    endfunction

    // Memory model: one read at a time, latency varied or fixed.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pending != 0) begin
            if (lat_cnt == 0) begin
                logic [31:0] rel;
                rel = (pend_addr - tbl_base) >> 3;
                mem_rsp_data  = (rel < 512) ? mem[rel[8:0]] : '0;
                mem_rsp_valid = 1'b1;
                pending = 0;
            end else begin
                lat_cnt--;
            end
        end else if (mem_req) begin
            if (n_reads < 32) addr_log[n_reads] = mem_addr;
            n_reads++;
            pend_addr = mem_addr;
            pending = 1;
            lat_seed++;
            lat_cnt = (fixed_lat >= 0) ? fixed_lat : ((lat_seed * 7) % 4);
        end
        if (rsp_valid) rsp_seen++;
    end

    task automatic fill_slot(input logic [5:0] idx, input logic [2:0] upto, input logic [7:0] pid, input logic [19:0] vpn);
        // Decoys at positions below 'upto': invalid same tag, or valid other pid.
        for (int k = 0; k < 8; k++) begin
            if (k < upto) begin
                if (k % 2 == 0) mem[{idx, 3'(k)}] = mk(1'b0, pid, vpn, 16'hdead);
                else            mem[{idx, 3'(k)}] = mk(1'b1, pid ^ 8'h01, vpn, 16'hbad0);
            end
        end
    endtask

    task automatic run_walk(input logic [19:0] vpn, input logic [7:0] pid, input logic [11:0] off,
                            input bit intrude, output bit got);
        int t;
        n_reads  = 0;
        rsp_seen = 0;
        got = 0;
        @(negedge clk);
        req_vpn = vpn; req_pid = pid; req_off = off; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            req_valid = 1'b1;
            req_vpn   = ~vpn;
            req_pid   = ~pid;
        end
        t = 0;
        while (!rsp_valid && t < 400) begin
            if (intrude) chk(req_ready == 1'b0, "R8 busy ready", {63'd0, req_ready}, 64'd0);
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        if (rsp_valid) got = 1;
        else chk(1'b0, "R9 walk timeout", 64'd0, 64'd1);
    endtask

    task automatic check_walk(input int vi, input vec_t v, input logic [31:0] base);
        bit          got;
        int          exp_reads;
        logic [5:0]  p_idx;
        logic [5:0]  s_idx;
        bit          seq_ok;
        logic [15:0] exp_ppn;
        bit          exp_hit;
        p_idx = ref_hash(v.pid, v.vpn);
        s_idx = ~p_idx;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        tbl_base = base;
        exp_hit = (v.where != 2'd2);
        exp_ppn = exp_hit ? v.ppn : 16'h0;
        case (v.where)
            2'd0: begin
                if (v.decoy) fill_slot(p_idx, v.way, v.pid, v.vpn);
                mem[{p_idx, v.way}] = mk(1'b1, v.pid, v.vpn, v.ppn);
                if (v.dup && v.way != 3'd7) mem[{p_idx, v.way + 3'd1}] = mk(1'b1, v.pid, v.vpn, ~v.ppn);
                exp_reads = v.way + 1;
            end
            2'd1: begin
                fill_slot(p_idx, 3'd7, v.pid, v.vpn);
                mem[{p_idx, 3'd7}] = mk(1'b0, v.pid, v.vpn, 16'h7777);
                if (v.decoy) fill_slot(s_idx, v.way, v.pid, v.vpn);
                mem[{s_idx, v.way}] = mk(1'b1, v.pid, v.vpn, v.ppn);
                if (v.dup && v.way != 3'd7) mem[{s_idx, v.way + 3'd1}] = mk(1'b1, v.pid, v.vpn, ~v.ppn);
                exp_reads = 8 + v.way + 1;
            end
            default: begin
                if (v.decoy) begin
                    fill_slot(p_idx, 3'd7, v.pid, v.vpn);
                    fill_slot(s_idx, 3'd7, v.pid, v.vpn);
                    mem[{p_idx, 3'd7}] = mk(1'b1, v.pid, v.vpn ^ 20'h1, 16'h6666);
                    mem[{s_idx, 3'd7}] = mk(1'b0, v.pid, v.vpn, 16'h6666);
                end
                exp_reads = 16;
            end
        endcase
        run_walk(v.vpn, v.pid, v.off, 1'b0, got);
        if (!got) return;
        chk(rsp_hit == exp_hit, $sformatf("R3 R6 hit v%0d", vi), {63'd0, rsp_hit}, {63'd0, exp_hit});
        chk(rsp_ppn == exp_ppn, $sformatf("R4 ppn v%0d", vi), {48'd0, rsp_ppn}, {48'd0, exp_ppn});
        if (exp_hit)
            chk(rsp_paddr == {v.ppn, v.off}, $sformatf("R7 paddr v%0d", vi), {36'd0, rsp_paddr}, {36'd0, v.ppn, v.off});
        chk(rsp_way == (exp_hit ? v.way : 3'd7), $sformatf("R4 way v%0d", vi), {61'd0, rsp_way}, {61'd0, exp_hit ? v.way : 3'd7});
        chk(rsp_secondary == (v.where != 2'd0), $sformatf("R5 secondary v%0d", vi),
            {63'd0, rsp_secondary}, {63'd0, v.where != 2'd0});
        chk(n_reads == exp_reads, $sformatf("R2 R4 R6 read count v%0d", vi), 64'(n_reads), 64'(exp_reads));
        seq_ok = 1;
        for (int i = 0; i < exp_reads && i < 32; i++) begin
            logic [31:0] ea;
            ea = base + ({26'd0, (i < 8) ? p_idx : s_idx} << 6) + (32'(i % 8) << 3);
            if (addr_log[i] != ea) begin
                if (seq_ok) chk(1'b0, $sformatf("R1 R2 R5 addr v%0d read %0d", vi, i), {32'd0, addr_log[i]}, {32'd0, ea});
                seq_ok = 0;
            end
        end
        if (seq_ok) chk(1'b1, "R1 addr seq", 64'd0, 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(rsp_seen == 1, $sformatf("R11 one pulse v%0d", vi), 64'(rsp_seen), 64'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit got;
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_pid = '0; req_off = '0;
        tbl_base = 32'h1000_0000; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready", {63'd0, req_ready}, 64'd1);
        chk(mem_req == 1'b0, "R10 mem_req", {63'd0, mem_req}, 64'd0);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);

        foreach (VECS[vi]) begin
            check_walk(vi, VECS[vi], 32'h1000_0000 + 32'(vi) * 32'h0001_0000);
        end

        // R9: long fixed latency gives the same result as vector 1
        fixed_lat = 20;
        check_walk(100, VECS[1], 32'h2000_0000);
        fixed_lat = 0;
        check_walk(101, VECS[4], 32'h2000_4000);
        fixed_lat = -1;

        // R8: requests presented while busy are ignored
        begin
            logic [5:0] pi;
            for (int i = 0; i < 512; i++) mem[i] = '0;
            tbl_base = 32'h3000_0000;
            pi = ref_hash(8'h44, 20'h0a0a0);
            mem[{pi, 3'd5}] = mk(1'b1, 8'h44, 20'h0a0a0, 16'hc0de);
            fixed_lat = 6;
            run_walk(20'h0a0a0, 8'h44, 12'h0f0, 1'b1, got);
            fixed_lat = -1;
            if (got) begin
                chk(rsp_hit && rsp_ppn == 16'hc0de, "R8 result of first request", {48'd0, rsp_ppn}, 64'hc0de);
                chk(n_reads == 6, "R8 read count", 64'(n_reads), 64'd6);
            end
            repeat (6) @(negedge clk);
            chk(n_reads == 6, "R8 no read after intruder dropped", 64'(n_reads), 64'd6);
            chk(rsp_seen == 1, "R11 R8 single response", 64'(rsp_seen), 64'd1);
            chk(req_ready == 1'b1, "R8 ready again", {63'd0, req_ready}, 64'd1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule